// File: doc/BRIEF.md
# Triple-Level Cell Program-and-Verify Sequencer

This block runs the incremental step-pulse programming loop for one page of charge-trap cells that store three bits each. A start pulse captures a page of 3-bit values and turns each value into one of eight threshold levels. The sequencer then alternates two phases. In a program pulse, the single gate shared by the whole page rises to a step voltage, and every cell that must not gain charge is held off by its inhibit bit. In a verify phase, the gate steps through the verify voltage of each level that still has unfinished cells, and the sequencer reads a per-cell sense vector at each of them.

A cell that reads as non-conducting at the verify voltage of its own target level is marked finished. It stays inhibited for every later pulse. Each later pulse starts 0.3 V above the one before it. The loop ends with a pass once every cell is finished, or with a fail once a set number of pulses has been used up. The analog array, the charge pump and the voltage DAC sit outside the block. Gate voltages leave the block as codes in units of 0.1 V.

Top module: `tlc_pv_seq`

## Requirements
- R1: After reset and while idle, busy, done and fail are 0, phase is 0, gate_code is 0 and inhibit is all zeros.
- R2: The data value of each cell (page_data bits [3i+2:3i]) selects its target level as follows: 111→0, 011→1, 001→2, 101→3, 100→4, 000→5, 010→6, 110→7. Level 0 is the erased state, and a cell at level 0 is inhibited from the first pulse onward.
- R3: Program pulse n (counting from 1) drives gate_code = PGM_BASE + PGM_STEP·(n−1). With the defaults this is 18.0 V, then 18.3 V, and so on. Each pulse lasts exactly PULSE_CYC cycles.
- R4: During a program pulse, inhibit[i] is 1 exactly for the cells that are erased-target or already verified. Outside a pulse, inhibit is all zeros.
- R5: After each pulse, the verify phase visits in ascending order only those levels 1..7 that still have unfinished cells. At level L it drives gate_code = VFY_BASE + VFY_STEP·(L−1) for SETTLE_CYC cycles, then samples sense.
- R6: sense[i] = 1 means the cell conducts. A cell whose target is the level under verify and whose sense is 0 at the sample becomes finished.
- R7: When every cell is finished, the operation ends with done high for exactly one cycle and fail 0. A page that contains only erased targets ends without any pulse.
- R8: If cells are still unfinished after MAX_LOOPS pulses, the operation ends with a one-cycle done pulse and fail = 1. fail stays at 1 until the next start.
- R9: phase is 1 during a program pulse, 2 during verify and 0 otherwise. busy is 1 from the cycle after an accepted start until done.
- R10: A start pulse, or a change of page_data, received while busy has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation on the page (accepted only when idle) |
| page_data | input | N*3 | Per-cell 3-bit data, cell i at bits [3i+2:3i] |
| sense | input | N | Per-cell conduct indication, 1 = on |
| gate_code | output | CODE_W | Shared gate voltage code in 0.1 V units |
| inhibit | output | N | Per-cell channel-bias inhibit during a pulse |
| phase | output | 2 | 0 idle, 1 program, 2 verify |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Result of the last operation: 1 = loop limit reached |

## Verification
The bench drives a behavioural array in which each cell gains a fixed threshold step per uninhibited pulse. It predicts the full order of gate codes: one program code per pulse, then the verify codes of the pending levels. A design that visited finished levels, or that visited levels out of order, would break that order. A design that kept pulsing a finished cell would leave that cell with more threshold shift than predicted. A design that swapped two entries of the Gray mapping would verify a cell at the wrong voltage and finish it after the wrong number of pulses. The other cases covered are a page of only erased cells (done with no pulse at all), a page that passes on exactly the last allowed pulse, a page that runs out of loops (fail held high), and a second start with new data in the middle of an operation, which must change nothing.

// File: rtl/tlc_pv_seq.sv
module tlc_pv_seq #(
  parameter int N          = 8,
  parameter int CODE_W     = 8,
  parameter int PULSE_CYC  = 10000,
  parameter int SETTLE_CYC = 20,
  parameter int MAX_LOOPS  = 24,
  parameter int PGM_BASE   = 180,
  parameter int PGM_STEP   = 3,
  parameter int VFY_BASE   = 5,
  parameter int VFY_STEP   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*3-1:0]    page_data,
  input  logic [N-1:0]      sense,
  output logic [CODE_W-1:0] gate_code,
  output logic [N-1:0]      inhibit,
  output logic [1:0]        phase,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int TMAX = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int LW   = $clog2(MAX_LOOPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_PGM, S_VFY} st_t;

  st_t           st;
  logic [2:0]    tgt [N];
  logic [N-1:0]  ok;
  logic [TW-1:0] tmr;
  logic [LW-1:0] loops;
  logic [2:0]    lvl, nxt, fst;
  logic [7:0]    pend;

  function automatic logic [2:0] level_of(input logic [2:0] d);
    case (d)
      3'b111:  level_of = 3'd0;
      3'b011:  level_of = 3'd1;
      3'b001:  level_of = 3'd2;
      3'b101:  level_of = 3'd3;
      3'b100:  level_of = 3'd4;
      3'b000:  level_of = 3'd5;
      3'b010:  level_of = 3'd6;
      default: level_of = 3'd7;
    endcase
  endfunction

  always_comb begin
    pend = '0;
    for (int i = 0; i < N; i++)
      if (!ok[i]) pend[tgt[i]] = 1'b1;
    pend[0] = 1'b0;
  end

  always_comb begin
    nxt = '0;
    fst = '0;
    for (int l = 7; l >= 1; l--) begin
      if (pend[l] && 3'(l) > lvl) nxt = 3'(l);
      if (pend[l]) fst = 3'(l);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ok    <= '0;
      tmr   <= '0;
      loops <= '0;
      lvl   <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
      for (int i = 0; i < N; i++) tgt[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < N; i++) begin
            tgt[i] <= level_of(page_data[3*i +: 3]);
            ok[i]  <= (level_of(page_data[3*i +: 3]) == 3'd0);
          end
          loops <= '0;
          fail  <= 1'b0;
          st    <= S_CHK;
        end
        S_CHK: begin
          tmr <= '0;
          if (&ok) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (loops == LW'(MAX_LOOPS)) begin
            done <= 1'b1;
            fail <= 1'b1;
            st   <= S_IDLE;
          end else st <= S_PGM;
        end
        S_PGM: if (tmr == TW'(PULSE_CYC - 1)) begin
          tmr   <= '0;
          loops <= loops + 1'b1;
          lvl   <= fst;
          st    <= S_VFY;
        end else tmr <= tmr + 1'b1;
        S_VFY: if (tmr == TW'(SETTLE_CYC - 1)) begin
          tmr <= '0;
          for (int i = 0; i < N; i++)
            if (tgt[i] == lvl && !sense[i]) ok[i] <= 1'b1;
          if (nxt != 3'd0) lvl <= nxt;
          else st <= S_CHK;
        end else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign phase     = (st == S_PGM) ? 2'd1 : (st == S_VFY) ? 2'd2 : 2'd0;
  assign inhibit   = (st == S_PGM) ? ok : '0;
  assign gate_code = (st == S_PGM) ? CODE_W'(PGM_BASE) + CODE_W'(PGM_STEP) * CODE_W'(loops)
                   : (st == S_VFY) ? CODE_W'(VFY_BASE) + CODE_W'(VFY_STEP) * CODE_W'(lvl - 3'd1)
                   : '0;
endmodule

// File: rtl/tlc_pv_seq_chk.sv
module tlc_pv_seq_chk #(
  parameter int N      = 8,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] gate_code,
  input logic [N-1:0]      inhibit,
  input logic [1:0]        phase,
  input logic              busy,
  input logic              done,
  input logic              fail
);
  a_r4_no_inhibit_outside_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd1 |-> inhibit == '0);

  a_r4_inhibit_steady_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && $past(phase) == 2'd1) |-> $stable(inhibit) && $stable(gate_code));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && phase == 2'd0);

  a_r8_fail_rises_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);

  a_r9_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3 && (phase != 2'd0 -> busy));

  a_r1_idle_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd0 |-> gate_code == '0);
endmodule

bind tlc_pv_seq tlc_pv_seq_chk #(.N(N), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate_code(gate_code), .inhibit(inhibit),
  .phase(phase), .busy(busy), .done(done), .fail(fail)
);

// File: tb/tlc_pv_seq_tb_top.sv
module tlc_pv_seq_tb_top;
  localparam int N = 8, CW = 8, PC = 20, SC = 3, ML = 6;
  localparam int PB = 180, PS = 3, VB = 5, VS = 6, VT0 = -5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [N*3-1:0] page_data = '0;
  logic [N-1:0] sense, inhibit;
  logic [CW-1:0] gate_code;
  logic [1:0] phase;
  logic busy, done, fail;

  always #5 clk = ~clk;

  tlc_pv_seq #(.N(N), .CODE_W(CW), .PULSE_CYC(PC), .SETTLE_CYC(SC), .MAX_LOOPS(ML),
    .PGM_BASE(PB), .PGM_STEP(PS), .VFY_BASE(VB), .VFY_STEP(VS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .page_data(page_data), .sense(sense),
    .gate_code(gate_code), .inhibit(inhibit), .phase(phase), .busy(busy),
    .done(done), .fail(fail));

  int tests = 0, fails = 0, cyc = 0;
  int vt [N];
  int inc [N];
  int npulse [N];
  int exp_q [$];
  int prev_ev = 0, plen = 0, done_cnt = 0;
  logic [1:0] prev_ph = 0;
  logic [N-1:0] inh_seen = '0;

  always_comb
    for (int i = 0; i < N; i++) sense[i] = (vt[i] < int'(gate_code));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [2:0] data_of(input int l);
    case (l)
      0: data_of = 3'b111; 1: data_of = 3'b011; 2: data_of = 3'b001; 3: data_of = 3'b101;
      4: data_of = 3'b100; 5: data_of = 3'b000; 6: data_of = 3'b010; default: data_of = 3'b110;
    endcase
  endfunction

  // monitor: scoreboard pop on each new gate event, array model update
  always @(negedge clk) begin
    if (rst_n) begin
      int ev;
      ev = int'(phase) * 1000 + int'(gate_code);
      if (phase == 2'd1) begin
        plen++;
        inh_seen = inhibit;
      end
      if (prev_ph == 2'd1 && phase != 2'd1) begin
        chk(plen == PC, "R3 pulse length", plen, PC);
        for (int i = 0; i < N; i++)
          if (!inh_seen[i]) begin vt[i] += inc[i]; npulse[i]++; end
        plen = 0;
      end
      if (phase != 2'd0 && ev != prev_ev) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected gate event", ev, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(ev == e, "R3/R5 gate event (phase*1000+code)", ev, e);
        end
      end
      if (done) done_cnt++;
      prev_ev = (phase == 2'd0) ? 0 : ev;
      prev_ph = phase;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL R7 watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // driver: compute expectation, push to queue, run operation, check result
  task automatic run_op(input int lv [N], input int ic [N], input bit restart, input string name);
    int k [N];
    int kmax = 0, p_tot, w;
    bit exp_fail;
    for (int i = 0; i < N; i++) begin
      vt[i] = VT0; inc[i] = ic[i]; npulse[i] = 0;
      page_data[3*i +: 3] = data_of(lv[i]);
      if (lv[i] == 0) k[i] = 0;
      else k[i] = (VB + VS * (lv[i] - 1) - VT0 + ic[i] - 1) / ic[i];
      if (k[i] > kmax) kmax = k[i];
    end
    exp_fail = (kmax > ML);
    p_tot = exp_fail ? ML : kmax;
    for (int p = 1; p <= p_tot; p++) begin
      exp_q.push_back(1000 + PB + PS * (p - 1));
      for (int l = 1; l <= 7; l++) begin
        bit pend = 0;
        for (int i = 0; i < N; i++) if (lv[i] == l && k[i] >= p) pend = 1;
        if (pend) exp_q.push_back(2000 + VB + VS * (l - 1));
      end
    end
    done_cnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, {"R9 busy after start ", name}, busy, 1);
    if (restart) begin
      repeat (30) @(negedge clk);
      for (int i = 0; i < N; i++) page_data[3*i +: 3] = 3'b110;
      start = 1; @(negedge clk); start = 0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done == 1, {"R7 done seen ", name}, done, 1);
    chk(fail == exp_fail, {"R8 fail flag ", name}, fail, exp_fail);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {"R7/R10 single done pulse ", name}, done_cnt, 1);
    chk(fail == exp_fail, {"R8 fail held ", name}, fail, exp_fail);
    chk(exp_q.size() == 0, {"R5 events left in queue ", name}, exp_q.size(), 0);
    exp_q.delete();
    for (int i = 0; i < N; i++) begin
      int ep;
      ep = (k[i] < p_tot) ? k[i] : p_tot;
      chk(npulse[i] == ep, {"R2/R4/R6 pulses seen by cell ", name}, npulse[i], ep);
    end
  endtask

  initial begin
    int lv [N];
    int ic [N];
    for (int i = 0; i < N; i++) begin vt[i] = VT0; inc[i] = 1; npulse[i] = 0; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0, "R1 reset flags", {busy, done, fail}, 0);
    chk(phase == 0 && gate_code == 0 && inhibit == 0, "R1 reset outputs", gate_code, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && phase == 0, "R1 idle after reset", busy, 0);

    // R2: all erased page, no pulse at all
    for (int i = 0; i < N; i++) begin lv[i] = 0; ic[i] = 8; end
    run_op(lv, ic, 0, "all-erased");

    // R3 R5 R6: all levels, passing on the last allowed pulse
    for (int i = 0; i < N; i++) begin lv[i] = i; ic[i] = 8; end
    run_op(lv, ic, 0, "all-levels");

    // R5: only two levels pending, with varied cell speeds
    lv = '{2, 6, 0, 2, 6, 6, 0, 2};
    ic = '{4, 12, 5, 9, 10, 14, 3, 6};
    run_op(lv, ic, 0, "two-levels");

    // R10: second start with new data while busy
    lv = '{1, 3, 5, 7, 0, 4, 2, 6};
    ic = '{6, 7, 8, 9, 10, 11, 12, 13};
    run_op(lv, ic, 1, "restart-ignored");

    // R8: loop limit reached
    for (int i = 0; i < N; i++) begin lv[i] = (i == 0) ? 0 : 7; ic[i] = 5; end
    run_op(lv, ic, 0, "loop-limit");

    // R8: fail clears on next start
    for (int i = 0; i < N; i++) begin lv[i] = 1; ic[i] = 20; end
    run_op(lv, ic, 0, "after-fail");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule